// File: doc/BRIEF.md
# Recursive Second-Order Luminance Smoother

This block low-pass filters a stream of 8-bit luminance samples with a double real pole at γ. Its gain at DC is exactly one, so flat regions keep their level. It accepts one sample on every cycle in which `in_valid` is high and never stalls. It is one stage of a separable smoothing chain: the same block is placed four times, once for each scan direction along rows and once for each scan direction along columns. The block keeps no position state apart from its two recursion registers, so it behaves the same whichever way the samples are ordered. Chroma does not pass through this block.

A 3-bit smoothing code picks the pole as γ = code/8. Code 0 passes samples through unchanged, and larger codes blur more strongly. The code is sampled with every pixel. A start-of-line flag loads both recursion registers with the first pixel of the line, so the image border does not cause a dark transient. The recursion runs in fixed point with 8 fractional bits. The output is rounded and clamped to 0..255, and appears one cycle after its input.

Top module: `lum_iir2_smoother`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` and `out_pix` are 0. Reset clears both recursion registers to 0, so a first line sent without `in_sol` starts from a zero history.
- R2: `out_valid` equals `in_valid` of the previous cycle. Every accepted sample produces exactly one output, with no stall.
- R3: A cycle with `in_valid` low changes neither recursion register, and `out_pix` holds its previous value.
- R4: When `in_valid` and `in_sol` are both high, the output in the next cycle equals the input pixel, and both recursion registers are loaded with that pixel scaled by 256.
- R5: For every code, a line whose samples all hold the same value produces that exact value at every output.
- R6: The pole is γ = code/8 with code = `smooth_code` in 0..7. Code 0 makes every output equal to its input pixel.
- R7: For a valid sample without `in_sol`, the new state is y = (16c·y1 − c²·y2 + (8−c)²·256·x + 32) >>> 6, where c is the code, y1 is the newest state, y2 is the older state and >>> is an arithmetic shift. Afterwards y2 takes the old y1 and y1 takes y.
- R8: The output pixel is (y + 128) >>> 8, clamped to 0 when negative and to 255 when above 255.
- R9: A change of `smooth_code` in the middle of a line applies from the next sample on. It does not clear the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_sol | input | 1 | First sample of a line |
| in_pix | input | 8 | Input luminance sample |
| smooth_code | input | 3 | Smoothing code, γ = code/8 |
| out_valid | output | 1 | Output sample present |
| out_pix | output | 8 | Smoothed, rounded and clamped sample |

## Verification
The hardest case to reach from the ports is the clamp. With a fixed code the impulse response is positive and sums to one, so the output can never leave 0..255. The stimulus therefore uses code 0 to put a sharp edge into the two recursion registers, one full-scale and one empty, and then switches to code 7 for the next sample. In that sample the feedback term overshoots, past 255 after a rising edge and below 0 after a falling edge. Every output is also compared with an integer model of the difference equation, for step and impulse lines at all eight codes.

// File: rtl/smth_pkg.sv
package smth_pkg;

    localparam int PIX_W  = 8;
    localparam int FRAC_W = 8;
    localparam int CODE_W = 3;
    localparam int CF_W   = 2 * CODE_W;
    localparam int CW     = CF_W + 1;

    typedef struct packed {
        logic [CW-1:0] fb1;
        logic [CW-1:0] fb2;
        logic [CW-1:0] ff;
    } coef_t;

    function automatic coef_t coef_for(input int unsigned c);
        coef_t       r;
        int unsigned full;
        full  = 1 << CODE_W;
        r.fb1 = CW'(2 * c * full);
        r.fb2 = CW'(c * c);
        r.ff  = CW'((full - c) * (full - c));
        return r;
    endfunction

endpackage

// File: rtl/smth_coef_tbl.sv
module smth_coef_tbl
    import smth_pkg::*;
#(
    parameter int N_CODE_W = CODE_W
) (
    input  logic [N_CODE_W-1:0] code,
    output coef_t               coef
);
    localparam int N_CODES = 1 << N_CODE_W;

    coef_t tbl [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_row
        assign tbl[g] = coef_for(g);
    end

    assign coef = tbl[code];
endmodule

// File: rtl/smth_core.sv
module smth_core
    import smth_pkg::*;
#(
    parameter int P_W  = PIX_W,
    parameter int F_W  = FRAC_W,
    parameter int C_FW = CF_W,
    parameter int SW   = P_W + F_W + 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_sol,
    input  logic [P_W-1:0]       in_pix,
    input  coef_t                coef,
    output logic signed [SW-1:0] y_next
);
    localparam int AW  = SW + C_FW + 3;
    localparam int RND = 1 << (C_FW - 1);

    logic signed [SW-1:0] y1_q, y2_q;
    logic signed [SW-1:0] x_s;
    logic signed [AW-1:0] y1_w, y2_w, x_w, c1_w, c2_w, c0_w, acc;
    logic signed [AW-1:0] shifted;

    assign x_s  = SW'({in_pix, {F_W{1'b0}}});
    assign y1_w = AW'(y1_q);
    assign y2_w = AW'(y2_q);
    assign x_w  = AW'(x_s);
    assign c1_w = AW'({1'b0, coef.fb1});
    assign c2_w = AW'({1'b0, coef.fb2});
    assign c0_w = AW'({1'b0, coef.ff});

    always_comb begin
        acc     = c1_w * y1_w - c2_w * y2_w + c0_w * x_w + AW'(RND);
        shifted = acc >>> C_FW;
        y_next  = in_sol ? x_s : SW'(shifted);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y1_q <= '0;
            y2_q <= '0;
        end else if (in_valid) begin
            y1_q <= y_next;
            y2_q <= in_sol ? x_s : y1_q;
        end
    end
endmodule

// File: rtl/smth_outstage.sv
module smth_outstage #(
    parameter int P_W = 8,
    parameter int F_W = 8,
    parameter int SW  = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] y_next,
    output logic                 out_valid,
    output logic [P_W-1:0]       out_pix
);
    localparam int HALF = 1 << (F_W - 1);
    localparam int PMAX = (1 << P_W) - 1;

    logic signed [SW-1:0] rnd, q;
    logic [P_W-1:0]       clamped;

    always_comb begin
        rnd = y_next + SW'(HALF);
        q   = rnd >>> F_W;
        if (q < 0)
            clamped = '0;
        else if (q > $signed(SW'(PMAX)))
            clamped = P_W'(PMAX);
        else
            clamped = q[P_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_pix <= clamped;
        end
    end
endmodule

// File: rtl/lum_iir2_smoother.sv
module lum_iir2_smoother
    import smth_pkg::*;
#(
    parameter int P_W = PIX_W,
    parameter int F_W = FRAC_W,
    parameter int C_W = CODE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           in_sol,
    input  logic [P_W-1:0] in_pix,
    input  logic [C_W-1:0] smooth_code,
    output logic           out_valid,
    output logic [P_W-1:0] out_pix
);
    localparam int SW   = P_W + F_W + 4;
    localparam int C_FW = 2 * C_W;

    coef_t                coef;
    logic signed [SW-1:0] y_next;

    smth_coef_tbl #(.N_CODE_W(C_W)) u_tbl (
        .code (smooth_code),
        .coef (coef)
    );

    smth_core #(.P_W(P_W), .F_W(F_W), .C_FW(C_FW), .SW(SW)) u_core (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .in_pix   (in_pix),
        .coef     (coef),
        .y_next   (y_next)
    );

    smth_outstage #(.P_W(P_W), .F_W(F_W), .SW(SW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .y_next    (y_next),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );
endmodule

// File: rtl/smth_chk.sv
module smth_chk #(
    parameter int P_W = 8,
    parameter int C_W = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           in_sol,
    input logic [P_W-1:0] in_pix,
    input logic [C_W-1:0] smooth_code,
    input logic           out_valid,
    input logic [P_W-1:0] out_pix
);
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_no_out_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_pix));

    p_sol_passes_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sol) |=> (out_pix == $past(in_pix)));

    p_code0_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && smooth_code == '0) |=> (out_pix == $past(in_pix)));
endmodule

bind lum_iir2_smoother smth_chk #(.P_W(P_W), .C_W(C_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_sol      (in_sol),
    .in_pix      (in_pix),
    .smooth_code (smooth_code),
    .out_valid   (out_valid),
    .out_pix     (out_pix)
);

// File: tb/lum_iir2_smoother_tb.sv
module lum_iir2_smoother_tb;

    localparam int    NONE = 511;
    localparam time   TCK  = 8ns;

    typedef struct packed {
        logic        v;
        logic        sol;
        logic [2:0]  code;
        logic [7:0]  pix;
        logic [8:0]  exp;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 3'd4, 8'd0,   9'd0,   "R4"},
        '{1'b1, 1'b0, 3'd4, 8'd255, 9'd64,  "R7"},
        '{1'b1, 1'b0, 3'd4, 8'd255, 9'd128, "R7"},
        '{1'b0, 1'b0, 3'd4, 8'd9,   9'd511, "R3"},
        '{1'b0, 1'b1, 3'd6, 8'd77,  9'd511, "R3"},
        '{1'b1, 1'b0, 3'd4, 8'd255, 9'd175, "R3"},
        '{1'b1, 1'b1, 3'd2, 8'd0,   9'd0,   "R4"},
        '{1'b1, 1'b0, 3'd2, 8'd200, 9'd511, "R7"},
        '{1'b1, 1'b0, 3'd2, 8'd0,   9'd511, "R7"},
        '{1'b1, 1'b0, 3'd2, 8'd0,   9'd511, "R7"},
        '{1'b1, 1'b0, 3'd5, 8'd0,   9'd511, "R9"},
        '{1'b1, 1'b0, 3'd1, 8'd90,  9'd511, "R9"},
        '{1'b1, 1'b0, 3'd0, 8'd37,  9'd37,  "R6"},
        '{1'b1, 1'b0, 3'd0, 8'd250, 9'd250, "R6"},
        '{1'b1, 1'b0, 3'd0, 8'd0,   9'd0,   "R6"},
        '{1'b1, 1'b0, 3'd0, 8'd255, 9'd255, "R6"},
        '{1'b1, 1'b0, 3'd7, 8'd255, 9'd255, "R8"},
        '{1'b1, 1'b1, 3'd0, 8'd255, 9'd255, "R4"},
        '{1'b1, 1'b0, 3'd0, 8'd0,   9'd0,   "R6"},
        '{1'b1, 1'b0, 3'd7, 8'd0,   9'd0,   "R8"},
        '{1'b1, 1'b1, 3'd3, 8'd10,  9'd10,  "R4"},
        '{1'b1, 1'b0, 3'd3, 8'd240, 9'd511, "R7"},
        '{1'b1, 1'b0, 3'd6, 8'd240, 9'd511, "R9"},
        '{1'b1, 1'b0, 3'd6, 8'd240, 9'd511, "R9"}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_sol;
    logic [7:0] in_pix;
    logic [2:0] smooth_code;
    logic       out_valid;
    logic [7:0] out_pix;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    done   = 1'b0;
    longint m_y1  = 0;
    longint m_y2  = 0;
    int    m_last = 0;

    always #(TCK / 2) clk = ~clk;

    lum_iir2_smoother u_dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_sol      (in_sol),
        .in_pix      (in_pix),
        .smooth_code (smooth_code),
        .out_valid   (out_valid),
        .out_pix     (out_pix)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Integer model of R4, R7 and R8; returns the expected output pixel.
    function automatic int model_step(input bit sol, input int c, input int x);
        longint xs, acc, yn, q;
        xs = longint'(x) * 256;
        if (sol) begin
            yn = xs;
            m_y2 = xs;
        end else begin
            acc = 16 * c * m_y1 - c * c * m_y2 + (8 - c) * (8 - c) * xs + 32;
            yn = acc >>> 6;
            m_y2 = m_y1;
        end
        m_y1 = yn;
        q = (yn + 128) >>> 8;
        if (q < 0) q = 0;
        if (q > 255) q = 255;
        return int'(q);
    endfunction

    task automatic drive(input bit v, input bit sol, input int c, input int x,
                         input int exp, input string tag);
        int m;
        in_valid    = v;
        in_sol      = sol;
        smooth_code = 3'(c);
        in_pix      = 8'(x);
        @(posedge clk);
        #1;
        check({tag, " valid"}, int'(out_valid), int'(v));  // R2
        if (v) begin
            m = model_step(sol, c, x);
            m_last = m;
            check(tag, int'(out_pix), m);
            if (exp != NONE) check({tag, " hand"}, int'(out_pix), exp);
        end else begin
            check({tag, " hold"}, int'(out_pix), m_last);   // R3
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0; in_sol = 1'b0; in_pix = '0; smooth_code = '0;
        @(posedge clk); #1;
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 pix in reset",   int'(out_pix), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        m_y1 = 0; m_y2 = 0; m_last = 0;
        @(posedge clk); #1;
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 pix after reset",   int'(out_pix), 0);
    endtask

    initial begin
        do_reset();

        // R1: zero history without a line start, code 4, x=255 -> 64
        drive(1, 0, 4, 255, 64, "R1");

        for (int i = 0; i < NV; i++)
            drive(TBL[i].v, TBL[i].sol, int'(TBL[i].code), int'(TBL[i].pix),
                  int'(TBL[i].exp), string'(TBL[i].tag));

        // R5: flat lines keep their exact level at every code
        for (int c = 0; c < 8; c++) begin
            drive(1, 1, c, 100 + 17 * c, 100 + 17 * c, "R5");
            for (int k = 0; k < 5; k++)
                drive(1, 0, c, 100 + 17 * c, 100 + 17 * c, "R5");
        end

        // R7/R6: step and impulse lines for all eight codes
        for (int c = 0; c < 8; c++) begin
            drive(1, 1, c, 0, 0, "R4");
            for (int k = 0; k < 6; k++) drive(1, 0, c, 255, NONE, "R7");
            drive(1, 1, c, 0, 0, "R4");
            drive(1, 0, c, 255, NONE, "R7");
            for (int k = 0; k < 5; k++) drive(1, 0, c, 0, NONE, "R7");
        end

        // R1: reset in mid-line clears the history
        drive(1, 1, 5, 200, 200, "R4");
        drive(1, 0, 5, 200, 200, "R5");
        do_reset();
        drive(1, 0, 4, 255, 64, "R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(TCK * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule